// File: doc/BRIEF.md
# Compare-Match Timer Channel

A single timer channel holding a 32-bit up-counter, a 32-bit compare value and a 16-bit control/status word. All three are reached through a plain register port with a write strobe, a two-bit address and a combinational read-data output. The counter advances on a tick taken from a prescaler. Four divide ratios can be selected, and the remaining selector codes stop the count. Counting goes on only while the `run` input is high. When the counter equals the compare value on a tick, the channel sets a match flag. Depending on the mode bit, the counter then either restarts from zero or keeps counting. A wrap from all-ones to zero without a match sets an overflow flag.

Writes do not land at once, so that a slower count domain behind a synchronizer can be modelled. Control and compare writes take effect two clocks after the write. A counter write takes three clocks. During those three clocks a pending bit is readable, and a second counter write in that window is dropped. The flags clear only when software writes a zero into their bit position. The match flag drives an interrupt line when interrupt requests are selected, and a one-cycle request pulse when DMA requests are selected.

The register port carries no streamed data, so it has no valid/ready pair. A write is accepted on every clock where `reg_wr` is high, and reads never stall.

Top module: `cmt_channel`

## Requirements
- R1: After reset the control/status word reads 0, the counter reads 0, the compare register reads 0xFFFFFFFF, and `irq` and `dma_req` are low. Register addresses are 0 for control/status, 1 for counter and 2 for compare. Address 3 reads 0 and ignores writes.
- R2: Control bits 2:0 select the tick. Code 7 divides the clock by 1, code 4 by 8, code 5 by 32 and code 6 by 128. Codes 0 to 3 give no tick, so the counter does not move.
- R3: While `run` is low the counter holds its value and the prescaler restarts. When `run` rises, the first tick comes after the full divide ratio.
- R4: With control bit 8 set, a tick that finds the counter equal to the compare value loads 0 and sets the match flag (bit 15). One period therefore lasts compare+1 ticks.
- R5: With control bit 8 clear, a match sets the match flag and the counter increments past the compare value.
- R6: A tick that wraps the counter from 0xFFFFFFFF to 0 without a match sets the overflow flag (bit 14).
- R7: A control write with bit 15 or bit 14 at zero clears that flag. Writing a one leaves the flag unchanged. A flag event in the same cycle as the clearing write wins.
- R8: A write to control or compare, sampled at clock edge k, takes effect at edge k+2. Reads return the old value until then.
- R9: A counter write sampled at edge k sets the pending bit (bit 13) until edge k+3, where the value is loaded. A counter write made while the bit is set is ignored. A loaded 0 reads back as 0.
- R10: `irq` is high exactly while the match flag is set and bits 5:4 equal 2'b10. It stays high until the flag is cleared.
- R11: When bits 5:4 equal 2'b01, every match event produces a one-cycle `dma_req` pulse in the following cycle. With 2'b00, neither `irq` nor `dma_req` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 counter, 2 compare) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request, level |
| dma_req | output | 1 | DMA request, one-cycle pulse |

## Verification
The match logic is exercised in several ways:
- At divide-by-1 with a small compare value, in both restart and free-running mode. Each match then lands in a cycle that is easy to predict, and the two modes separate clearly.
- At the slower divide ratios, which separate the prescaler codes from each other. A halting code and a low `run` show that the count truly stops.
- With a counter preset near all-ones, which tells an overflow apart from a match.
- With back-to-back counter writes, which separate an accepted write from one dropped during the pending window.
- With flag writes of both polarities, which tell a clear from a keep.
- With interrupt, DMA and no-request selections, run against each other.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CTRL_W   = 16;
  localparam int B_MATCH  = 15;
  localparam int B_OVF    = 14;
  localparam int B_PEND   = 13;
  localparam int B_MODE   = 8;
  localparam int B_REQ_LO = 4;
  localparam int B_CKS_LO = 0;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_DMA  = 2'd1,
    REQ_IRQ  = 2'd2,
    REQ_RSVD = 2'd3
  } req_sel_e;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       restart;
    req_sel_e   req;
    logic [2:0] cks;
  } cfg_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] cks,
  output logic       tick
);
  localparam logic [PRE_W-1:0] M_DIV1   = '0;
  localparam logic [PRE_W-1:0] M_DIV8   = PRE_W'(7);
  localparam logic [PRE_W-1:0] M_DIV32  = PRE_W'(31);
  localparam logic [PRE_W-1:0] M_DIV128 = PRE_W'(127);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             sel_ok;

  always_comb begin
    sel_ok = 1'b1;
    case (cks)
      3'd7:    mask = M_DIV1;
      3'd4:    mask = M_DIV8;
      3'd5:    mask = M_DIV32;
      3'd6:    mask = M_DIV128;
      default: begin
        mask   = M_DIV1;
        sel_ok = 1'b0;
      end
    endcase
  end

  assign tick = run && sel_ok && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
    else          pre_q <= '0;
  end
endmodule

// File: rtl/cmt_wr_sync.sv
module cmt_wr_sync #(
  parameter int W   = 32,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         fire,
  output logic [W-1:0] fire_data,
  output logic         busy
);
  logic [LAT-1:0] vld_q;
  logic [W-1:0]   dat_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < LAT; i++) dat_q[i] <= '0;
    end else begin
      vld_q[0] <= wr;
      dat_q[0] <= wdata;
      for (int i = 1; i < LAT; i++) begin
        vld_q[i] <= vld_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
    end
  end

  assign fire      = vld_q[LAT-1];
  assign fire_data = dat_q[LAT-1];
  assign busy      = |vld_q;
endmodule

// File: rtl/cmt_core.sv
module cmt_core
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_load,
  input  logic [CTRL_W-1:0] cfg_data,
  input  logic              cmp_load,
  input  logic [CNT_W-1:0]  cmp_data,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cmp_q,
  output cfg_t              cfg_q,
  output logic              match_q,
  output logic              ovf_q,
  output logic              dma_q
);
  logic match_evt;
  logic ovf_evt;
  logic keep_match;
  logic keep_ovf;

  assign match_evt  = tick && !cnt_load && (cnt_q == cmp_q);
  assign ovf_evt    = tick && !cnt_load && !match_evt && (&cnt_q);
  assign keep_match = !cfg_load || cfg_data[B_MATCH];
  assign keep_ovf   = !cfg_load || cfg_data[B_OVF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_q   <= '1;
      cfg_q   <= '{restart: 1'b0, req: REQ_NONE, cks: 3'd0};
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      if (cnt_load)                      cnt_q <= cnt_data;
      else if (match_evt && cfg_q.restart) cnt_q <= '0;
      else if (tick)                     cnt_q <= cnt_q + 1'b1;

      if (cmp_load) cmp_q <= cmp_data;
      if (cfg_load) begin
        cfg_q.restart <= cfg_data[B_MODE];
        cfg_q.req     <= req_sel_e'(cfg_data[B_REQ_LO +: 2]);
        cfg_q.cks     <= cfg_data[B_CKS_LO +: 3];
      end

      match_q <= match_evt | (match_q & keep_match);
      ovf_q   <= ovf_evt   | (ovf_q & keep_ovf);
      dma_q   <= match_evt && (cfg_q.req == REQ_DMA);
    end
  end

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt_q == $past(cnt_data)); // R9
  AST_RESTART_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_load && cfg_q.restart && cnt_q == cmp_q |=> cnt_q == '0 && match_q); // R4
  AST_FREE_PAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_load && !cfg_q.restart && cnt_q == cmp_q |=> cnt_q == $past(cnt_q) + 1'b1 && match_q); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_load |=> $stable(cnt_q)); // R3
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(&cnt_q) && cnt_q == '0); // R6
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int CFG_WR_LAT = 2,
  parameter int CNT_WR_LAT = 3,
  parameter int PRE_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq,
  output logic             dma_req
);
  logic              wr_ctrl, wr_cnt, wr_cmp;
  logic              cfg_fire, cmp_fire, cnt_fire;
  logic [CTRL_W-1:0] cfg_fdata;
  logic [CNT_W-1:0]  cmp_fdata, cnt_fdata;
  logic              cfg_busy, cmp_busy, cnt_busy;
  logic              tick;
  logic [CNT_W-1:0]  cnt_q, cmp_q;
  cfg_t              cfg_q;
  logic              match_q, ovf_q, dma_q;
  logic [CTRL_W-1:0] ctrl_rd;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_cmp  = reg_wr && (reg_addr == ADDR_CMP);
  assign wr_cnt  = reg_wr && (reg_addr == ADDR_CNT) && !cnt_busy;

  cmt_wr_sync #(.W(CTRL_W), .LAT(CFG_WR_LAT)) u_cfg_sync (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(reg_wdata[CTRL_W-1:0]),
    .fire(cfg_fire), .fire_data(cfg_fdata), .busy(cfg_busy));

  cmt_wr_sync #(.W(CNT_W), .LAT(CFG_WR_LAT)) u_cmp_sync (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .wdata(reg_wdata),
    .fire(cmp_fire), .fire_data(cmp_fdata), .busy(cmp_busy));

  cmt_wr_sync #(.W(CNT_W), .LAT(CNT_WR_LAT)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .wr(wr_cnt), .wdata(reg_wdata),
    .fire(cnt_fire), .fire_data(cnt_fdata), .busy(cnt_busy));

  cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .cks(cfg_q.cks), .tick(tick));

  cmt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_load(cfg_fire), .cfg_data(cfg_fdata),
    .cmp_load(cmp_fire), .cmp_data(cmp_fdata),
    .cnt_load(cnt_fire), .cnt_data(cnt_fdata),
    .cnt_q(cnt_q), .cmp_q(cmp_q), .cfg_q(cfg_q),
    .match_q(match_q), .ovf_q(ovf_q), .dma_q(dma_q));

  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[B_MATCH]         = match_q;
    ctrl_rd[B_OVF]           = ovf_q;
    ctrl_rd[B_PEND]          = cnt_busy;
    ctrl_rd[B_MODE]          = cfg_q.restart;
    ctrl_rd[B_REQ_LO +: 2]   = cfg_q.req;
    ctrl_rd[B_CKS_LO +: 3]   = cfg_q.cks;
    case (reg_addr)
      ADDR_CTRL: reg_rdata = CNT_W'(ctrl_rd);
      ADDR_CNT:  reg_rdata = cnt_q;
      ADDR_CMP:  reg_rdata = cmp_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq     = match_q && (cfg_q.req == REQ_IRQ);
  assign dma_req = dma_q;

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cfg_fire |=> irq); // R10
  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_busy && !cnt_fire |=> cnt_busy); // R9
  AST_CFG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_busy |=> $stable(cfg_q)); // R8
  AST_CMP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_busy |=> $stable(cmp_q)); // R8
endmodule

// File: tb/cmt_channel_tb_top.sv
module cmt_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, dma_req;

  int n_chk = 0;
  int n_err = 0;
  string tag = "R1";
  int dma_seen = 0;

  always #5 clk = ~clk;

  cmt_channel dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .dma_req(dma_req));

  // behavioural reference
  logic [31:0] m_cnt, m_cmp;
  bit          m_restart, m_mf, m_of, m_dma;
  int          m_req, m_cks, m_pre;
  int          cyc = 0;
  logic [31:0] q_ctl_d[$], q_cmp_d[$], q_cnt_d[$];
  int          q_ctl_t[$], q_cmp_t[$], q_cnt_t[$];

  function automatic logic [31:0] m_read(input logic [1:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      2'd0: begin
        v[15] = m_mf; v[14] = m_of; v[13] = (q_cnt_t.size() > 0);
        v[8] = m_restart; v[5:4] = 2'(m_req); v[2:0] = 3'(m_cks);
      end
      2'd1: v = m_cnt;
      2'd2: v = m_cmp;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", t, act, exp, cyc);
    end
  endtask

  task automatic m_step();
    int mask; bit tk, ld, mt, ov, cap, busy0;
    logic [31:0] cd;
    case (m_cks)
      7: mask = 0; 4: mask = 7; 5: mask = 31; 6: mask = 127; default: mask = -1;
    endcase
    tk = run && mask >= 0 && ((m_pre & mask) == mask);
    ld = q_cnt_t.size() > 0 && q_cnt_t[0] == cyc;
    mt = tk && !ld && m_cnt == m_cmp;
    ov = tk && !ld && !mt && m_cnt == 32'hFFFF_FFFF;
    cap = q_ctl_t.size() > 0 && q_ctl_t[0] == cyc;
    cd = cap ? q_ctl_d[0] : '0;
    m_dma = mt && m_req == 1;
    if (ld) m_cnt = q_cnt_d[0];
    else if (mt && m_restart) m_cnt = 0;
    else if (tk) m_cnt = m_cnt + 1;
    m_mf = mt || (m_mf && (!cap || cd[15]));
    m_of = ov || (m_of && (!cap || cd[14]));
    if (cap) begin
      m_restart = cd[8]; m_req = int'(cd[5:4]); m_cks = int'(cd[2:0]);
      void'(q_ctl_d.pop_front()); void'(q_ctl_t.pop_front());
    end
    if (q_cmp_t.size() > 0 && q_cmp_t[0] == cyc) begin
      m_cmp = q_cmp_d.pop_front(); void'(q_cmp_t.pop_front());
    end
    busy0 = q_cnt_t.size() > 0;
    if (ld) begin void'(q_cnt_d.pop_front()); void'(q_cnt_t.pop_front()); end
    m_pre = run ? (m_pre + 1) % 128 : 0;
    if (reg_wr) begin
      case (reg_addr)
        2'd0: begin q_ctl_d.push_back(reg_wdata); q_ctl_t.push_back(cyc + 2); end
        2'd1: if (!busy0) begin q_cnt_d.push_back(reg_wdata); q_cnt_t.push_back(cyc + 3); end
        2'd2: begin q_cmp_d.push_back(reg_wdata); q_cmp_t.push_back(cyc + 2); end
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 32'hFFFF_FFFF; m_restart = 0; m_mf = 0; m_of = 0; m_dma = 0;
      m_req = 0; m_cks = 0; m_pre = 0;
      q_ctl_d.delete(); q_ctl_t.delete(); q_cmp_d.delete(); q_cmp_t.delete();
      q_cnt_d.delete(); q_cnt_t.delete();
    end else m_step();
    cyc++;
    #2;
    if (rst_n) begin
      check({tag, " R10 irq"}, {31'b0, irq}, {31'b0, m_mf && m_req == 2});
      check({tag, " R11 dma_req"}, {31'b0, dma_req}, {31'b0, m_dma});
      check({tag, " rdata"}, reg_rdata, m_read(reg_addr));
      if (dma_req) dma_seen++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string t);
    @(negedge clk); reg_addr = a; #1;
    check(t, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1;
    tag = "R1";
    rd(2'd0, 32'h0, "R1 ctrl reset"); rd(2'd1, 32'h0, "R1 cnt reset");
    rd(2'd2, 32'hFFFF_FFFF, "R1 cmp reset"); rd(2'd3, 32'h0, "R1 addr3");
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    wr(2'd3, 32'h1234); rd(2'd3, 32'h0, "R1 addr3 write ignored");

    tag = "R8";
    wr(2'd2, 32'd5); reg_addr = 2'd2; #1;
    check("R8 cmp old before apply", reg_rdata, 32'hFFFF_FFFF);
    idle(2); rd(2'd2, 32'd5, "R8 cmp applied");

    tag = "R4";
    wr(2'd0, 32'h0127); run = 1'b1; idle(20);
    check("R10 irq raised", {31'b0, irq}, 32'h1);
    tag = "R7";
    wr(2'd0, 32'h8127); idle(3);
    wr(2'd0, 32'h0127); idle(1); run = 1'b0; idle(3);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    run = 1'b1;

    tag = "R2";
    wr(2'd0, 32'h0124); idle(120);
    wr(2'd0, 32'h0125); idle(300);
    wr(2'd0, 32'h0126); wr(2'd2, 32'd2); idle(800);

    tag = "R5";
    wr(2'd0, 32'h0027); wr(2'd2, 32'd3); idle(30);

    tag = "R6";
    run = 1'b0; wr(2'd1, 32'hFFFF_FFF0); idle(5); wr(2'd0, 32'h0027);
    idle(3); run = 1'b1; idle(40);

    tag = "R3";
    run = 1'b0; idle(10); run = 1'b1; idle(10); run = 1'b0; idle(4);

    tag = "R9";
    wr(2'd1, 32'd100); wr(2'd1, 32'd200); idle(5);
    rd(2'd1, 32'd100, "R9 second write dropped");
    wr(2'd1, 32'd0); reg_addr = 2'd0; #1;
    check("R9 pending visible", reg_rdata & 32'h2000, 32'h2000);
    idle(4); rd(2'd1, 32'd0, "R9 zero read back");

    tag = "R2";
    wr(2'd0, 32'h0100); idle(3); run = 1'b1; idle(20);
    rd(2'd1, 32'd0, "R2 halt code no count");

    tag = "R11";
    wr(2'd0, 32'h0117); wr(2'd2, 32'd2); idle(40);
    check("R11 dma pulses seen", {31'b0, dma_seen > 0}, 32'h1);
    wr(2'd0, 32'h0107); idle(30);
    check("R11 none selection irq low", {31'b0, irq}, 32'h0);

    run = 1'b0; idle(5);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule